// File: doc/BRIEF.md
# Multi-Pin Edge Wake-Up Detector

This block watches an input port, one bit per pin, and records a chosen transition on each pin in a sticky flag. Software picks, pin by pin, whether a rising or a falling transition counts. Software also picks which pins may raise a wake request. The flags are recorded whether or not the pin is enabled, so software clears them before it enables a pin.

Three registers, one bit per pin, sit on a small register bus: an enable mask, a polarity mask and the flag register. The single output `wake_o` is high while at least one pin is both enabled and flagged. A power controller can use it to leave a low-power state, or to refuse to enter one.

Top module: `wk_wakeup_det`

## Requirements
- R1: The register address selects the register: 0 is the enable mask, 1 is the polarity mask and 2 is the flag register. Bit i of each register belongs to pin i. Address 3 reads as zero, and a write to address 3 changes no register.
- R2: Every register reads back the value last written to it. `reg_rdata_o` follows `reg_addr_i` combinationally, in the same cycle.
- R3: Reset clears the enable and polarity masks, and `wake_o` is low after reset. The flag register is not initialised by reset.
- R4: A polarity bit of 1 makes a high-to-low transition on that pin the trigger. A polarity bit of 0 makes a low-to-high transition the trigger. A transition in the other direction does not set the flag.
- R5: A set flag stays set until software writes the flag register. A later transition of either direction on the pin does not clear it.
- R6: A flag sets on its trigger transition even when the pin's enable bit is 0.
- R7: `wake_o` is high exactly when (enable AND flag) has at least one bit set. It follows the registers with no extra delay.
- R8: Each pin passes through two synchronizing flops, followed by one compare stage. Suppose a pin changes before clock edge k. Then its flag can be read after edge k+2 and not before.
- R9: A write to the flag register loads the written value. If a trigger for a pin is detected in the same cycle as a write that clears that pin's flag, the flag ends up set.
- R10: A change of a polarity bit does not by itself set the flag. The new polarity applies only to transitions sampled after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous port pins being watched |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | NPINS | Write data |
| reg_rdata_o | output | NPINS | Read data for the selected register |
| wake_o | output | 1 | Wake request: some pin is both enabled and flagged |

## Verification
On every cycle, the in-line assertions check four things. A detected transition shows in the flag register one cycle later, even if a write clears the flag in that same cycle. A flag only drops after a write to the flag register. A flag write with no competing transition loads the data exactly. Finally, every detected transition matches the selected polarity and a real change of the synchronized pin. Other behaviour depends on pin timing relative to register writes, and only the bench's scenarios can show it. This covers the exact three-edge latency, the lack of a false flag when a polarity bit flips under a steady pin, the enable masking on `wake_o`, and the ignored fourth address.

// File: rtl/wk_pkg.sv
package wk_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENABLE = 2'd0,
    SEL_POLAR  = 2'd1,
    SEL_FLAG   = 2'd2,
    SEL_VOID   = 2'd3
  } wk_sel_e;

  // Trigger test for one pin: fall_mode=1 wants 1->0, fall_mode=0 wants 0->1.
  function automatic logic trig_hit(input logic was, input logic now, input logic fall_mode);
    logic rise, fall;
    rise = ~was & now;
    fall = was & ~now;
    return fall_mode ? fall : rise;
  endfunction

  // Next flag bit: a write loads data, a trigger always forces the bit high.
  function automatic logic flag_next(input logic cur, input logic wr, input logic wdat,
                                     input logic hit);
    logic base;
    base = wr ? wdat : cur;
    return base | hit;
  endfunction

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/wk_edge.sv
module wk_edge
  import wk_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] fall_mode_i,
  output logic [NPINS-1:0] hit_o
);

  logic [NPINS-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level_i;
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign hit_o[i] = trig_hit(last_q[i], level_i[i], fall_mode_i[i]);

      // R8
      hit_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o[i] |-> (level_i[i] != $past(level_i[i])));

      // R4
      hit_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o[i] |-> (level_i[i] == ~fall_mode_i[i]));
    end
  endgenerate

endmodule

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  hit_i,
  output logic [NPINS-1:0]  enable_o,
  output logic [NPINS-1:0]  polar_o,
  output logic [NPINS-1:0]  flag_o,
  output logic [NPINS-1:0]  rdata_o
);

  logic [NPINS-1:0] enable_q, polar_q, flag_q, flag_d;
  logic             wr_enable, wr_polar, wr_flag;

  assign wr_enable = wr_i && (addr_i == SEL_ENABLE);
  assign wr_polar  = wr_i && (addr_i == SEL_POLAR);
  assign wr_flag   = wr_i && (addr_i == SEL_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      polar_q  <= '0;
    end else begin
      if (wr_enable) enable_q <= wdata_i;
      if (wr_polar)  polar_q  <= wdata_i;
    end
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_flag
      assign flag_d[i] = flag_next(flag_q[i], wr_flag, wdata_i[i], hit_i[i]);
    end
  endgenerate

  // Flags deliberately carry no reset value.
  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end

  always_comb begin
    unique case (addr_i)
      SEL_ENABLE: rdata_o = enable_q;
      SEL_POLAR:  rdata_o = polar_q;
      SEL_FLAG:   rdata_o = flag_q;
      default:    rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign polar_o  = polar_q;
  assign flag_o   = flag_q;

  // R3
  masks_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (enable_q == '0 && polar_q == '0));

  // R9
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((flag_q & $past(hit_i)) == $past(hit_i)));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R9
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && hit_i == '0) |=> (flag_q == $past(wdata_i)));

endmodule

// File: rtl/wk_wakeup_det.sv
module wk_wakeup_det
  import wk_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  output logic              wake_o
);

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_hit;
  logic [NPINS-1:0] enable_mask;
  logic [NPINS-1:0] polar_mask;
  logic [NPINS-1:0] flag_bits;
  logic [NPINS-1:0] armed_bits;

  wk_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  wk_edge #(.NPINS(NPINS)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_i     (pin_sync),
    .fall_mode_i (polar_mask),
    .hit_o       (pin_hit)
  );

  wk_regs #(.NPINS(NPINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .hit_i    (pin_hit),
    .enable_o (enable_mask),
    .polar_o  (polar_mask),
    .flag_o   (flag_bits),
    .rdata_o  (reg_rdata_o)
  );

  assign armed_bits = enable_mask & flag_bits;
  assign wake_o     = |armed_bits;

  // R6
  flag_ignores_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_hit & ~enable_mask)) |=> ((flag_bits & $past(pin_hit)) == $past(pin_hit)));

endmodule

// File: tb/wk_wakeup_det_tb_top.sv
module wk_wakeup_det_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [1:0]   addr = 2'd0;
  logic         wr = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  wk_wakeup_det #(.NPINS(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pins),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .wake_o      (wake)
  );

  // Vector fields: polarity, enable, pins before, pins after, expected flags, expected wake
  localparam logic [40:0] VEC [0:6] = '{
    {8'h00, 8'hFF, 8'h00, 8'h01, 8'h01, 1'b1},
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0},
    {8'hFF, 8'hFF, 8'hFF, 8'hF0, 8'h0F, 1'b1},
    {8'h0F, 8'h00, 8'h0F, 8'hF0, 8'hFF, 1'b0},
    {8'hAA, 8'h55, 8'hAA, 8'h55, 8'hFF, 1'b1},
    {8'hAA, 8'h0F, 8'h00, 8'hFF, 8'h55, 1'b1},
    {8'h00, 8'hF0, 8'h00, 8'h0F, 8'h0F, 1'b0}
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] r;
    repeat (3) @(negedge clk);

    // R3: reset state
    reg_read(2'd0, r); check("R3 enable after reset", r, 8'h00);
    reg_read(2'd1, r); check("R3 polarity after reset", r, 8'h00);
    check("R3 wake after reset", {7'd0, wake}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, r); check("R3 enable after release", r, 8'h00);
    check("R3 wake after release", {7'd0, wake}, 8'h00);

    // Vector table: R4 R6 R7
    for (int v = 0; v < 7; v++) begin
      pins = VEC[v][24:17];
      settle();
      reg_write(2'd0, 8'h00);
      reg_write(2'd1, VEC[v][40:33]);
      reg_write(2'd2, 8'h00);
      reg_write(2'd0, VEC[v][32:25]);
      pins = VEC[v][16:9];
      settle();
      reg_read(2'd2, r); check("R4/R6 flags from vector", r, VEC[v][8:1]);
      check("R7 wake from vector", {7'd0, wake}, {7'd0, VEC[v][0]});
    end

    // R5: sticky flag survives opposite transition
    reg_write(2'd0, 8'h00); reg_write(2'd1, 8'h00);
    pins = 8'h00; settle(); reg_write(2'd2, 8'h00);
    pins = 8'h10; settle();
    pins = 8'h00; repeat (10) @(negedge clk);
    reg_read(2'd2, r); check("R5 flag held", r, 8'h10);
    reg_write(2'd2, 8'h00);
    reg_read(2'd2, r); check("R5 flag cleared by write", r, 8'h00);

    // R2: readback
    reg_write(2'd0, 8'hA5); reg_read(2'd0, r); check("R2 enable readback", r, 8'hA5);
    reg_write(2'd1, 8'h3C); reg_read(2'd1, r); check("R2 polarity readback", r, 8'h3C);
    reg_write(2'd2, 8'h81); reg_read(2'd2, r); check("R2 flag readback", r, 8'h81);

    // R1: void address
    reg_write(2'd3, 8'hFF);
    reg_read(2'd3, r); check("R1 void address reads zero", r, 8'h00);
    reg_read(2'd0, r); check("R1 enable untouched", r, 8'hA5);
    reg_read(2'd1, r); check("R1 polarity untouched", r, 8'h3C);
    reg_read(2'd2, r); check("R1 flag untouched", r, 8'h81);

    // R7: written flag with enable mask
    reg_write(2'd2, 8'h04); reg_write(2'd0, 8'h04);
    check("R7 wake with match", {7'd0, wake}, 8'h01);
    reg_write(2'd0, 8'h08);
    check("R7 wake with no match", {7'd0, wake}, 8'h00);

    // R8: latency
    reg_write(2'd0, 8'h00); reg_write(2'd1, 8'h00); reg_write(2'd2, 8'h00);
    addr = 2'd2;
    @(negedge clk); pins = 8'h02;
    @(negedge clk); #1; check("R8 not after first edge", rdata, 8'h00);
    @(negedge clk); #1; check("R8 not after second edge", rdata, 8'h00);
    @(negedge clk); #1; check("R8 set after third edge", rdata, 8'h02);

    // R9: clear collides with trigger
    pins = 8'h00; settle(); reg_write(2'd2, 8'h00);
    @(negedge clk); pins = 8'h04;
    @(negedge clk);
    @(negedge clk);
    addr = 2'd2; wdata = 8'h00; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    reg_read(2'd2, r); check("R9 trigger beats clear", r, 8'h04);
    reg_write(2'd2, 8'h00);

    // R10: polarity flip with steady pins
    pins = 8'hFF; settle(); reg_write(2'd2, 8'h00);
    reg_write(2'd1, 8'hFF); settle();
    reg_read(2'd2, r); check("R10 no flag on polarity flip high", r, 8'h00);
    pins = 8'h00; settle();
    reg_read(2'd2, r); check("R10 new polarity used", r, 8'hFF);
    reg_write(2'd2, 8'h00);
    reg_write(2'd1, 8'h00); settle();
    reg_read(2'd2, r); check("R10 no flag on polarity flip low", r, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule